// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block holds a small group of interval timer channels behind one register bus. Each channel has an up-counter that advances once per period of a selectable clock divider. On each advance the count is compared with a programmable limit register. When the count equals the limit, the count returns to zero and a sticky match flag is raised. The flag drives the channel's interrupt line when the channel's interrupt enable is set. Counting is gated by one run bit per channel, and all run bits sit together in a single shared run register.

The block can be built for a narrow variant (`CNT_W = 16`) or a wide variant (`CNT_W = 32`). The positions of the flag and enable bits in the status word depend on the variant. The wide variant adds a second sticky flag for a counter that passes all-ones without a match.

Software sets up a channel in this order: stop it, program the divider, enable and limit, then set its run bit. It clears the flag from the interrupt service routine by writing the status word back with the flag at zero.

The register bus has no back-pressure. A write completes in the cycle where `bus_wr` is high, and read data follows `bus_addr` in the same cycle.

Top module: `match_timer`

## Requirements
- R1: After reset, every channel reads a count of 0, a limit of all ones and a status word of 0. The run register reads 0 and every `irq` bit is low.
- R2: While a channel's run bit is 1, its count rises by exactly one per divider period. While the run bit is 0, the count holds its value.
- R3: Bits [1:0] of the status word select the divider: 0 gives divide-by-8, 1 gives divide-by-32, 2 gives divide-by-128 and 3 gives divide-by-512. In the wide variant the select field is bits [2:0], and bit 2 is stored and read back but does not change the divisor. All dividers are derived from one free-running prescale counter.
- R4: On a divider tick where the count equals the limit, the count becomes 0 and the match flag is set. The match flag is bit 7 in the narrow variant and bit 15 in the wide variant.
- R5: A flag is cleared by writing 0 to its bit and is left unchanged by writing 1; a write never sets a flag. In the wide variant this rule covers both bit 15 and bit 14. All other status bits take the written value. A flag set in the same cycle as a clearing write stays set.
- R6: `irq[i]` is high exactly while a flag of channel i is set and its interrupt enable bit is 1. The enable is bit 6 in the narrow variant and bit 5 in the wide variant. Writing 0 to the status word drops the interrupt.
- R7: The run register is shared by all channels. Bit i runs channel i, bits at NUM_CH and above read 0, and the channel field of the address is ignored for this register. A read-modify-write that changes one bit leaves the other channels counting without interruption.
- R8: A new limit written while a channel runs is used from the next tick on. In the wide variant, a count that passes all ones without a match wraps to 0 and sets bit 14, and the match flag is not set.
- R9: A write to the count register loads the written value. If that write falls in the same cycle as a match, the written value wins and the match flag is still set.
- R10: `bus_addr[1:0]` selects the register: 0 is the status word, 1 is the count, 2 is the limit and 3 is the run register. The higher address bits select the channel. The status word is 16 bits wide, and its upper read bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the block and the prescaler |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe; the write completes at this clock edge |
| bus_addr | input | CH_W+2 | Channel index in the upper bits, register select in bits [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | NUM_CH | Per-channel interrupt, level, flag AND enable |

## Verification
The hardest case to reach is a count write that lands on the exact clock edge where a divider tick meets count equal to limit. The tick phase cannot be seen at the ports. The bench therefore polls the count every cycle until it first reads the limit, which places it just after a tick edge. It then waits one divider period less one cycle and issues the write, so the write is taken on the next tick. A similar alignment is used for the wide-variant wrap case. There the count is loaded just below all ones after the limit has been lowered under it.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int BUS_W        = 32;
  localparam int CSR_W        = 16;
  localparam int NUM_DIV      = 4;
  localparam int DIV_BASE_LOG = 3;
  localparam int DIV_STEP_LOG = 2;
  localparam int PRE_W        = DIV_BASE_LOG + DIV_STEP_LOG * (NUM_DIV - 1);
  localparam int WRAP_FLAG_POS = 14;

  typedef enum logic [1:0] {
    RSEL_CSR   = 2'd0,
    RSEL_COUNT = 2'd1,
    RSEL_LIMIT = 2'd2,
    RSEL_RUN   = 2'd3
  } rsel_e;

  function automatic int match_flag_pos(int cw);
    return (cw == 16) ? 7 : 15;
  endfunction

  function automatic int irq_en_pos(int cw);
    return (cw == 16) ? 6 : 5;
  endfunction

  function automatic bit has_wrap_flag(int cw);
    return cw != 16;
  endfunction
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler
  import mt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  output logic [NUM_DIV-1:0] tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + PRE_W'(1);
  end

  // one pulse per divider period, taken from the low bits all being ones
  for (genvar k = 0; k < NUM_DIV; k++) begin : g_div
    localparam int LW = DIV_BASE_LOG + DIV_STEP_LOG * k;
    assign tick[k] = &pre_q[LW-1:0];
  end
endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load_cnt,
  input  logic             load_lim,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o,
  output logic             hit_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic             at_top;

  assign at_top = (cnt_q == {CNT_W{1'b1}});
  assign hit_o  = step && (cnt_q == lim_q);
  assign wrap_o = step && !hit_o && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_cnt) begin
      cnt_q <= wdata;
    end else if (hit_o || wrap_o) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lim_q <= '1;
    else if (load_lim) lim_q <= wdata;
  end

  assign cnt_o = cnt_q;
  assign lim_o = lim_q;
endmodule

// File: rtl/mt_csr.sv
module mt_csr
  import mt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CSR_W-1:0] wdata,
  input  logic             hit,
  input  logic             wrap,
  output logic [CSR_W-1:0] csr_o,
  output logic [1:0]       sel_o,
  output logic             irq_o
);
  localparam int MFP  = match_flag_pos(CNT_W);
  localparam int IEP  = irq_en_pos(CNT_W);
  localparam bit HASW = has_wrap_flag(CNT_W);
  localparam logic [CSR_W-1:0] FLAG_MASK =
    (CSR_W'(1) << MFP) | (HASW ? (CSR_W'(1) << WRAP_FLAG_POS) : '0);

  logic [CSR_W-1:0] plain_q;
  logic             mflag_q;
  logic             wflag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  plain_q <= '0;
    else if (wr) plain_q <= wdata & ~FLAG_MASK;
  end

  // flags: writing zero clears, writing one keeps, a new event wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mflag_q <= 1'b0;
    else if (wr) mflag_q <= (mflag_q & wdata[MFP]) | hit;
    else         mflag_q <= mflag_q | hit;
  end

  if (HASW) begin : g_wrap
    logic wflag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  wflag_q <= 1'b0;
      else if (wr) wflag_q <= (wflag_q & wdata[WRAP_FLAG_POS]) | wrap;
      else         wflag_q <= wflag_q | wrap;
    end
    assign wflag = wflag_q;
  end else begin : g_nowrap
    logic unused_wrap;
    assign unused_wrap = wrap;
    assign wflag = 1'b0;
  end

  always_comb begin
    csr_o      = plain_q;
    csr_o[MFP] = mflag_q;
    if (HASW) csr_o[WRAP_FLAG_POS] = wflag;
  end

  assign sel_o = plain_q[1:0];
  assign irq_o = (mflag_q | wflag) & plain_q[IEP];
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int MFP = match_flag_pos(CNT_W);
  localparam int IEP = irq_en_pos(CNT_W);

  rsel_e                         rsel;
  logic [CH_W-1:0]               ch_idx;
  logic [NUM_DIV-1:0]            tick;
  logic [NUM_CH-1:0]             run_q;
  logic [NUM_CH-1:0]             step_a, ld_cnt_a, ld_lim_a, wr_csr_a;
  logic [NUM_CH-1:0]             mflag_a, ien_a;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_a, lim_a;
  logic [NUM_CH-1:0][CSR_W-1:0]  csr_a;
  logic [NUM_CH-1:0][1:0]        sel_a;
  logic [NUM_CH-1:0]             hit_a, wrap_a;

  assign rsel   = rsel_e'(bus_addr[1:0]);
  assign ch_idx = bus_addr[ADDR_W-1:2];

  mt_prescaler u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  // shared run register, one bit per channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          run_q <= '0;
    else if (bus_wr && rsel == RSEL_RUN) run_q <= bus_wdata[NUM_CH-1:0];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit_me;
    assign hit_me      = (ch_idx == CH_W'(i));
    assign wr_csr_a[i] = bus_wr && hit_me && (rsel == RSEL_CSR);
    assign ld_cnt_a[i] = bus_wr && hit_me && (rsel == RSEL_COUNT);
    assign ld_lim_a[i] = bus_wr && hit_me && (rsel == RSEL_LIMIT);
    assign step_a[i]   = run_q[i] && tick[sel_a[i]];

    mt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step_a[i]),
      .load_cnt (ld_cnt_a[i]),
      .load_lim (ld_lim_a[i]),
      .wdata    (bus_wdata[CNT_W-1:0]),
      .cnt_o    (cnt_a[i]),
      .lim_o    (lim_a[i]),
      .hit_o    (hit_a[i]),
      .wrap_o   (wrap_a[i])
    );

    mt_csr #(.CNT_W(CNT_W)) u_csr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_csr_a[i]),
      .wdata (bus_wdata[CSR_W-1:0]),
      .hit   (hit_a[i]),
      .wrap  (wrap_a[i]),
      .csr_o (csr_a[i]),
      .sel_o (sel_a[i]),
      .irq_o (irq[i])
    );

    assign mflag_a[i] = csr_a[i][MFP];
    assign ien_a[i]   = csr_a[i][IEP];
  end

  always_comb begin
    bus_rdata = '0;
    if (rsel == RSEL_RUN) begin
      bus_rdata[NUM_CH-1:0] = run_q;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_idx == CH_W'(i)) begin
          case (rsel)
            RSEL_CSR:   bus_rdata[CSR_W-1:0] = csr_a[i];
            RSEL_COUNT: bus_rdata[CNT_W-1:0] = cnt_a[i];
            RSEL_LIMIT: bus_rdata[CNT_W-1:0] = lim_a[i];
            default:    bus_rdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [31:0]                 bus_wdata,
  input logic [NUM_CH-1:0]           irq,
  input logic [NUM_CH-1:0]           run_q,
  input logic [NUM_CH-1:0]           step_a,
  input logic [NUM_CH-1:0]           ld_cnt_a,
  input logic [NUM_CH-1:0]           wr_csr_a,
  input logic [NUM_CH-1:0]           mflag_a,
  input logic [NUM_CH-1:0]           ien_a,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_a,
  input logic [NUM_CH-1:0][CNT_W-1:0] lim_a
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_p
    assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[i] && !ld_cnt_a[i]) |=> $stable(cnt_a[i]));

    assert_match_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_a[i] && !ld_cnt_a[i] && cnt_a[i] == lim_a[i]) |=> (cnt_a[i] == '0 && mflag_a[i]));

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mflag_a[i] && !wr_csr_a[i]) |=> mflag_a[i]);

    assert_irq_follows_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mflag_a[i] && ien_a[i] && !wr_csr_a[i]) |=> irq[i]);

    assert_count_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ld_cnt_a[i] |=> (cnt_a[i] == $past(bus_wdata[CNT_W-1:0])));
  end
endmodule

bind match_timer match_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .run_q     (run_q),
  .step_a    (step_a),
  .ld_cnt_a  (ld_cnt_a),
  .wr_csr_a  (wr_csr_a),
  .mflag_a   (mflag_a),
  .ien_a     (ien_a),
  .cnt_a     (cnt_a),
  .lim_a     (lim_a)
);

// File: tb/match_timer_tb.sv
`timescale 1ns/1ps
module match_timer_tb;
  localparam int NUM_CH = 2;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 3;
  localparam logic [1:0] A_CSR = 2'd0, A_CNT = 2'd1, A_LIM = 2'd2, A_RUN = 2'd3;
  localparam int MF = 15, WF = 14, IE = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NUM_CH-1:0] irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  match_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic ch, input logic [1:0] r, input logic [31:0] d);
    bus_addr  = {ch, r};
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic ch, input logic [1:0] r, output logic [31:0] d);
    bus_addr = {ch, r};
    #1;
    d = bus_rdata;
  endtask

  // cycles between two consecutive count changes
  task automatic measure(input logic ch, output int n);
    logic [31:0] a, b;
    int guard;
    rd(ch, A_CNT, a);
    b = a;
    guard = 0;
    while (b == a && guard < 2000) begin
      @(negedge clk); rd(ch, A_CNT, b); guard++;
    end
    a = b;
    n = 0;
    while (b == a && n < 2000) begin
      @(negedge clk); rd(ch, A_CNT, b); n++;
    end
  endtask

  task automatic setup_ch(input logic ch, input logic [31:0] csr, input logic [31:0] lim);
    wr(ch, A_CSR, csr);
    wr(ch, A_CNT, 32'd0);
    wr(ch, A_LIM, lim);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, A_CSR, v); chk("R1 csr", v, 32'h0);
    rd(0, A_CNT, v); chk("R1 count", v, 32'h0);
    rd(1, A_LIM, v); chk("R1 limit", v, 32'hFFFF_FFFF);
    rd(0, A_RUN, v); chk("R1 run", v, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_rate;
    int n;
    logic [31:0] a, b;
    setup_ch(0, 32'h0, 32'hFFFF_FFFF);
    wr(0, A_RUN, 32'h1);
    measure(0, n); chk("R2 R3 div8 period", 32'(n), 32'd8);
    wr(0, A_CSR, 32'h1);
    measure(0, n); chk("R3 div32 period", 32'(n), 32'd32);
    wr(0, A_CSR, 32'h6);
    measure(0, n); chk("R3 div128 period (bit2 ignored)", 32'(n), 32'd128);
    rd(0, A_CSR, a); chk("R3 select readback", a, 32'h6);
    wr(0, A_CSR, 32'h3);
    measure(0, n); chk("R3 div512 period", 32'(n), 32'd512);
    wr(0, A_RUN, 32'h0);
    wr(0, A_CSR, 32'h0);
    rd(0, A_CNT, a);
    repeat (40) @(negedge clk);
    rd(0, A_CNT, b); chk("R2 hold when stopped", b, a);
  endtask

  task automatic t_match;
    logic [31:0] v;
    logic [31:0] mx;
    int g;
    setup_ch(0, 32'h1 << IE, 32'd3);
    wr(0, A_RUN, 32'h1);
    g = 0;
    while (irq[0] !== 1'b1 && g < 200) begin @(negedge clk); g++; end
    chk("R6 irq raised", 32'(irq[0]), 32'h1);
    rd(0, A_CSR, v); chk("R4 match flag", 32'(v[MF]), 32'h1);
    mx = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); rd(0, A_CNT, v); if (v > mx) mx = v;
    end
    chk("R4 count never passes limit", 32'(mx <= 32'd3), 32'h1);
    wr(0, A_RUN, 32'h0);
  endtask

  task automatic t_flags;
    logic [31:0] v;
    wr(0, A_CSR, 32'hABCD_8120);
    rd(0, A_CSR, v); chk("R5 R10 write one keeps flag, upper zero", v, 32'h8120);
    chk("R6 irq with enable", 32'(irq[0]), 32'h1);
    wr(0, A_CSR, 32'h0000_8000);
    rd(0, A_CSR, v); chk("R6 enable off", v, 32'h8000);
    chk("R6 irq gated", 32'(irq[0]), 32'h0);
    wr(0, A_CSR, 32'h0);
    rd(0, A_CSR, v); chk("R5 write zero clears", v, 32'h0);
    wr(0, A_CSR, 32'hC000);
    rd(0, A_CSR, v); chk("R5 write one does not set", v, 32'h0);
  endtask

  task automatic t_shared;
    logic [31:0] r, a0, a1, b0, b1;
    setup_ch(0, 32'h0, 32'hFFFF_FFFF);
    setup_ch(1, 32'h0, 32'hFFFF_FFFF);
    wr(1, A_RUN, 32'hFFFF);
    rd(0, A_RUN, r); chk("R7 unused run bits read zero", r, 32'h3);
    repeat (40) @(negedge clk);
    rd(0, A_RUN, r);
    wr(0, A_RUN, r & ~32'h2);
    rd(0, A_CNT, a0); rd(1, A_CNT, a1);
    repeat (32) @(negedge clk);
    rd(0, A_CNT, b0); rd(1, A_CNT, b1);
    chk("R7 other channel stopped", b1, a1);
    chk("R7 R2 kept channel advances 4 in 32 cycles", b0 - a0, 32'd4);
    wr(0, A_RUN, 32'h0);
  endtask

  task automatic t_rewrite;
    logic [31:0] v, c;
    int g;
    setup_ch(0, 32'h0, 32'd100);
    wr(0, A_RUN, 32'h1);
    g = 0; rd(0, A_CNT, v);
    while (v < 10 && g < 300) begin @(negedge clk); rd(0, A_CNT, v); g++; end
    wr(0, A_LIM, 32'd5);
    repeat (24) @(negedge clk);
    rd(0, A_CNT, v); chk("R8 count passes lowered limit", 32'(v > 32'd10), 32'h1);
    wr(0, A_CNT, 32'hFFFF_FFFD);
    g = 0; rd(0, A_CNT, v);
    while (v > 32'h10 && g < 100) begin @(negedge clk); rd(0, A_CNT, v); g++; end
    rd(0, A_CSR, v); chk("R8 wrap flag only", v, 32'h1 << WF);
    g = 0; rd(0, A_CSR, v);
    while (v[MF] == 1'b0 && g < 200) begin @(negedge clk); rd(0, A_CSR, v); g++; end
    rd(0, A_CNT, c);
    chk("R8 new limit matches", 32'(v[MF]), 32'h1);
    chk("R8 count zero at match", c, 32'h0);
    wr(0, A_RUN, 32'h0);
    wr(0, A_CSR, 32'h0);
    rd(0, A_CSR, v); chk("R5 both flags cleared", v, 32'h0);
  endtask

  task automatic t_write_race;
    logic [31:0] v;
    int g;
    setup_ch(0, 32'h0, 32'd2);
    wr(0, A_RUN, 32'h1);
    g = 0; rd(0, A_CNT, v);
    while (v != 32'd2 && g < 200) begin @(negedge clk); rd(0, A_CNT, v); g++; end
    repeat (7) @(posedge clk);
    @(negedge clk);
    wr(0, A_CNT, 32'h55);
    rd(0, A_CNT, v); chk("R9 write wins over match", v, 32'h55);
    rd(0, A_CSR, v); chk("R9 flag still set", 32'(v[MF]), 32'h1);
    wr(0, A_RUN, 32'h0);
    wr(0, A_CSR, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rate();
    t_match();
    t_flags();
    t_shared();
    t_rewrite();
    t_write_race();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule